// File: doc/BRIEF.md
# Registered Accumulating ALU Datapath

This block wraps a 16-bit arithmetic and logic unit with the clocked and steering logic a datapath needs around it. Two operand registers, A and B, sit in front of the ALU. Each has its own load enable. A single bypass control lets the raw inputs reach the ALU directly, and while it is set the registers still keep loading. An operand-select stage in front of the ALU can force either operand to zero. It can also return the output register to the B side, which turns the block into an accumulator.

The ALU result feeds an output register. That register has its own load enable and its own bypass. The feedback into the B side always comes from the register itself, even while the output pins show the unregistered result. An active-low output enable decides whether the block drives a shared bus. The bus is modelled as a data value plus a drive flag, and the value reads zero when the block is not driving.

All registers share one rising-edge clock and a synchronous active-high reset.

Top module: `acc_alu_dp`

## Requirements
- R1: Operand register A loads `a_in` on a rising edge when `a_ld_n` is 0 and holds its value when `a_ld_n` is 1. Operand register B works the same way with `b_in` and `b_ld_n`.
- R2: While `in_bypass` is 1, the ALU uses `a_in`/`b_in` in the same cycle, and the operand registers keep loading under their enables. Once `in_bypass` returns to 0, the ALU again uses the stored register values.
- R3: The output register captures the ALU result on a rising edge when `f_ld_n` is 0 and holds its value when `f_ld_n` is 1. With `out_bypass` at 0, `f_out` shows this register.
- R4: While `out_bypass` is 1, `f_out` shows the ALU result in the same cycle, and the output register keeps loading under `f_ld_n`. Once `out_bypass` returns to 0, the held register value reappears.
- R5: `opnd_sel[1]` picks the B-side source and `opnd_sel[0]` picks the A-side source: 2'b00 gives B side = output register and A side = A; 2'b01 gives B side = 0 and A side = A; 2'b10 gives B side = B and A side = 0; 2'b11 gives B side = B and A side = A.
- R6: The B-side feedback comes from the output register whatever the value of `out_bypass`.
- R7: The `op_sel` codes are: 3'b000 gives all zeros; 3'b001 gives NOT(A)+B+`carry_in`; 3'b010 gives A+NOT(B)+`carry_in`; 3'b011 gives A+B+`carry_in`; 3'b100 gives XOR; 3'b101 gives OR; 3'b110 gives AND; 3'b111 gives all ones. Sums wrap modulo 2^16, and A and B here mean the selected operands.
- R8: When `oe_n` is 1, `f_drive` is 0 and `f_out` is 0. When `oe_n` is 0, `f_drive` is 1 and `f_out` carries the selected result.
- R9: A rising edge with `rst` at 1 clears the A, B and output registers.
- R10: An accumulation runs in three phases. First, code 000 with `f_ld_n` at 0 clears the accumulator. Next, an add with `opnd_sel` at 2'b01 preloads it from A. Finally, adds with `opnd_sel` at 2'b00 sum each new A into it. This holds for all four settings of the two bypass controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Operand A data |
| b_in | input | 16 | Operand B data |
| a_ld_n | input | 1 | Active-low load enable of the A register |
| b_ld_n | input | 1 | Active-low load enable of the B register |
| in_bypass | input | 1 | Route a_in/b_in around the operand registers |
| opnd_sel | input | 2 | Operand source select (bit 1 B side, bit 0 A side) |
| op_sel | input | 3 | ALU function code |
| carry_in | input | 1 | Carry into the arithmetic functions |
| f_ld_n | input | 1 | Active-low load enable of the output register |
| out_bypass | input | 1 | Route the ALU result around the output register |
| oe_n | input | 1 | Active-low output drive enable |
| f_out | output | 16 | Result value, zero when not driven |
| f_drive | output | 1 | High when the block drives the result bus |

## Verification
Results that pass through a bypass and the combinational ALU are due in the same cycle as the stimulus. The bench therefore changes inputs shortly after a clock edge and samples them a nanosecond later, well before the next edge. A value that has to enter the A, B or output register first becomes visible only after one rising edge. An accumulation step with a registered A input takes two edges: one to load A and one to load the sum. The bench's tasks advance exactly that many edges and sample 2 ns after the last one, so no check falls on an edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ZERO  = 3'b000,
        OP_BMINA = 3'b001,
        OP_AMINB = 3'b010,
        OP_ADD   = 3'b011,
        OP_XOR   = 3'b100,
        OP_OR    = 3'b101,
        OP_AND   = 3'b110,
        OP_ONES  = 3'b111
    } alu_op_e;

    // Operand source select: bit 1 chooses the B side, bit 0 the A side.
    typedef enum logic [1:0] {
        SEL_FB_A   = 2'b00,
        SEL_ZERO_A = 2'b01,
        SEL_B_ZERO = 2'b10,
        SEL_B_A    = 2'b11
    } opnd_sel_e;

endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic           cin,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [W-1:0]   res
);
    localparam int SW = W + 1;

    logic [SW-1:0] sum_ext;
    logic [W-1:0]  add_l;
    logic [W-1:0]  add_r;

    always_comb begin
        add_l = x;
        add_r = y;
        unique case (op)
            OP_BMINA: add_l = ~x;
            OP_AMINB: add_r = ~y;
            default: ;
        endcase
        sum_ext = {1'b0, add_l} + {1'b0, add_r} + {{(SW-1){1'b0}}, cin};
    end

    always_comb begin
        unique case (op)
            OP_ZERO:  res = '0;
            OP_BMINA,
            OP_AMINB,
            OP_ADD:   res = sum_ext[W-1:0];
            OP_XOR:   res = x ^ y;
            OP_OR:    res = x | y;
            OP_AND:   res = x & y;
            default:  res = '1;
        endcase
    end
endmodule

// File: rtl/acc_opnd_mux.sv
module acc_opnd_mux
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  opnd_sel_e      sel,
    input  logic [W-1:0]   a_src,
    input  logic [W-1:0]   b_src,
    input  logic [W-1:0]   fb_src,
    output logic [W-1:0]   x,
    output logic [W-1:0]   y
);
    always_comb begin
        unique case (sel)
            SEL_FB_A:   begin x = a_src; y = fb_src; end
            SEL_ZERO_A: begin x = a_src; y = '0;     end
            SEL_B_ZERO: begin x = '0;    y = b_src;  end
            default:    begin x = a_src; y = b_src;  end
        endcase
    end
endmodule

// File: rtl/acc_out_stage.sv
module acc_out_stage #(
    parameter int W = 16
) (
    input  logic           bypass,
    input  logic           oe_n,
    input  logic [W-1:0]   live,
    input  logic [W-1:0]   held,
    output logic [W-1:0]   bus_val,
    output logic           bus_drive
);
    logic [W-1:0] chosen;

    always_comb begin
        chosen    = bypass ? live : held;
        bus_drive = ~oe_n;
        bus_val   = bus_drive ? chosen : '0;
    end
endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
    import acc_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic           a_ld_n,
    input  logic           b_ld_n,
    input  logic           in_bypass,
    input  logic [1:0]     opnd_sel,
    input  logic [2:0]     op_sel,
    input  logic           carry_in,
    input  logic           f_ld_n,
    input  logic           out_bypass,
    input  logic           oe_n,
    output logic [W-1:0]   f_out,
    output logic           f_drive
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] f;
    } regs_t;

    regs_t        regs_d;
    regs_t        regs_q;
    logic [W-1:0] a_eff;
    logic [W-1:0] b_eff;
    logic [W-1:0] alu_x;
    logic [W-1:0] alu_y;
    logic [W-1:0] alu_res;

    // Operand source: bypass sends the raw inputs on, registers still load.
    always_comb begin
        a_eff = in_bypass ? a_in : regs_q.a;
        b_eff = in_bypass ? b_in : regs_q.b;
    end

    acc_opnd_mux #(.W(W)) u_mux (
        .sel    (opnd_sel_e'(opnd_sel)),
        .a_src  (a_eff),
        .b_src  (b_eff),
        .fb_src (regs_q.f),
        .x      (alu_x),
        .y      (alu_y)
    );

    acc_alu_core #(.W(W)) u_core (
        .op  (alu_op_e'(op_sel)),
        .cin (carry_in),
        .x   (alu_x),
        .y   (alu_y),
        .res (alu_res)
    );

    always_comb begin
        regs_d = regs_q;
        if (!a_ld_n) regs_d.a = a_in;
        if (!b_ld_n) regs_d.b = b_in;
        if (!f_ld_n) regs_d.f = alu_res;
        if (rst)     regs_d   = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    acc_out_stage #(.W(W)) u_out (
        .bypass    (out_bypass),
        .oe_n      (oe_n),
        .live      (alu_res),
        .held      (regs_q.f),
        .bus_val   (f_out),
        .bus_drive (f_drive)
    );
endmodule

// File: rtl/acc_alu_dp_chk.sv
module acc_alu_dp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         a_ld_n,
    input logic         b_ld_n,
    input logic         f_ld_n,
    input logic         out_bypass,
    input logic         oe_n,
    input logic [W-1:0] f_out,
    input logic         f_drive,
    input logic [W-1:0] a_q,
    input logic [W-1:0] b_q,
    input logic [W-1:0] f_q,
    input logic [W-1:0] alu_res
);
    assert_a_load_R1: assert property (@(posedge clk) disable iff (rst)
        !a_ld_n |=> a_q == $past(a_in));
    assert_a_hold_R1: assert property (@(posedge clk) disable iff (rst)
        a_ld_n |=> $stable(a_q));
    assert_b_load_R1: assert property (@(posedge clk) disable iff (rst)
        !b_ld_n |=> b_q == $past(b_in));
    assert_f_load_R3: assert property (@(posedge clk) disable iff (rst)
        !f_ld_n |=> f_q == $past(alu_res));
    assert_f_hold_R3: assert property (@(posedge clk) disable iff (rst)
        f_ld_n |=> $stable(f_q));
    assert_bypass_out_R4: assert property (@(posedge clk) disable iff (rst)
        (out_bypass && !oe_n) |-> f_out == alu_res);
    assert_held_out_R3: assert property (@(posedge clk) disable iff (rst)
        (!out_bypass && !oe_n) |-> f_out == f_q);
    assert_no_drive_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!f_drive && f_out == '0));
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (a_q == '0 && b_q == '0 && f_q == '0));
endmodule

bind acc_alu_dp acc_alu_dp_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .b_in       (b_in),
    .a_ld_n     (a_ld_n),
    .b_ld_n     (b_ld_n),
    .f_ld_n     (f_ld_n),
    .out_bypass (out_bypass),
    .oe_n       (oe_n),
    .f_out      (f_out),
    .f_drive    (f_drive),
    .a_q        (regs_q.a),
    .b_q        (regs_q.b),
    .f_q        (regs_q.f),
    .alu_res    (alu_res)
);

// File: tb/acc_alu_dp_tb.sv
module acc_alu_dp_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         a_ld_n, b_ld_n, in_bypass, carry_in, f_ld_n, out_bypass, oe_n;
    logic [1:0]   opnd_sel;
    logic [2:0]   op_sel;
    logic [W-1:0] f_out;
    logic         f_drive;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    acc_alu_dp #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .a_ld_n(a_ld_n), .b_ld_n(b_ld_n), .in_bypass(in_bypass),
        .opnd_sel(opnd_sel), .op_sel(op_sel), .carry_in(carry_in),
        .f_ld_n(f_ld_n), .out_bypass(out_bypass), .oe_n(oe_n),
        .f_out(f_out), .f_drive(f_drive)
    );

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One rising edge, then settle 2 ns past it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        a_ld_n = 1; b_ld_n = 1; f_ld_n = 1;
        carry_in = 0; oe_n = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle(); a_in = 0; b_in = 0; in_bypass = 0; out_bypass = 0;
        opnd_sel = 2'b11; op_sel = 3'b011;
        tick(); tick();
        rst = 0; #1;
        check("R9 output register after reset", f_out, 16'h0000);
        out_bypass = 1; #1;
        check("R9 A+B of cleared operand registers", f_out, 16'h0000);
    endtask

    task automatic t_input_regs();
        in_bypass = 0; out_bypass = 1; opnd_sel = 2'b11; op_sel = 3'b011;
        a_in = 16'h1234; b_in = 16'h0101; a_ld_n = 0; b_ld_n = 0;
        tick();
        check("R1 both operands loaded", f_out, 16'h1335);
        a_ld_n = 1; a_in = 16'hFFFF; b_in = 16'h0002;
        tick();
        check("R1 A held, B reloaded", f_out, 16'h1236);
        b_ld_n = 1;
    endtask

    task automatic t_in_bypass();
        in_bypass = 1; out_bypass = 1; opnd_sel = 2'b11; op_sel = 3'b011;
        a_in = 16'h0005; b_in = 16'h0007; a_ld_n = 0; b_ld_n = 0; #1;
        check("R2 raw inputs reach ALU same cycle", f_out, 16'h000C);
        tick();
        a_ld_n = 1; b_ld_n = 1; a_in = 16'h0100; b_in = 16'h0100; #1;
        check("R2 bypass still shows raw inputs", f_out, 16'h0200);
        in_bypass = 0; #1;
        check("R2 registers loaded during bypass reappear", f_out, 16'h000C);
    endtask

    task automatic t_ops();
        logic [W-1:0] exp_tab [8];
        exp_tab = '{16'h0000, 16'h0E1E, 16'hF1E0, 16'h0FFF,
                    16'h0FFF, 16'h0FFF, 16'h0000, 16'hFFFF};
        in_bypass = 1; out_bypass = 1; opnd_sel = 2'b11;
        a_in = 16'h00F0; b_in = 16'h0F0F; carry_in = 0;
        for (int i = 0; i < 8; i++) begin
            op_sel = i[2:0]; #1;
            check($sformatf("R7 op code %0d", i), f_out, exp_tab[i]);
        end
        carry_in = 1;
        op_sel = 3'b001; #1;
        check("R7 B minus A with carry in", f_out, 16'h0E1F);
        op_sel = 3'b010; #1;
        check("R7 A minus B with carry in", f_out, 16'hF1E1);
        carry_in = 0;
    endtask

    task automatic t_opsel();
        in_bypass = 1; out_bypass = 1; op_sel = 3'b011;
        a_in = 16'h0030; b_in = 16'h0004;
        opnd_sel = 2'b01; #1;
        check("R5 code 01 zero B side", f_out, 16'h0030);
        opnd_sel = 2'b10; #1;
        check("R5 code 10 zero A side", f_out, 16'h0004);
        opnd_sel = 2'b11; #1;
        check("R5 code 11 both operands", f_out, 16'h0034);
        opnd_sel = 2'b01; f_ld_n = 0;
        tick();
        f_ld_n = 1; opnd_sel = 2'b00; #1;
        check("R5 code 00 feedback on B side", f_out, 16'h0060);
    endtask

    task automatic t_out_reg();
        in_bypass = 1; out_bypass = 0; opnd_sel = 2'b11; op_sel = 3'b011;
        a_in = 16'h0001; b_in = 16'h0002; f_ld_n = 0;
        tick();
        check("R3 result captured", f_out, 16'h0003);
        f_ld_n = 1; a_in = 16'h000A;
        tick();
        check("R3 register held with load disabled", f_out, 16'h0003);
    endtask

    task automatic t_out_bypass();
        in_bypass = 1; out_bypass = 1; opnd_sel = 2'b11; op_sel = 3'b011;
        a_in = 16'h0040; b_in = 16'h0000; f_ld_n = 0; #1;
        check("R4 live result on output", f_out, 16'h0040);
        tick();
        f_ld_n = 1; a_in = 16'h0055; #1;
        check("R4 live result follows input", f_out, 16'h0055);
        out_bypass = 0; #1;
        check("R4 register loaded during bypass reappears", f_out, 16'h0040);
    endtask

    task automatic t_oe();
        oe_n = 1; #1;
        check("R8 drive flag low", {15'd0, f_drive}, 16'h0000);
        check("R8 value zero when not driving", f_out, 16'h0000);
        oe_n = 0; #1;
        check("R8 drive flag high", {15'd0, f_drive}, 16'h0001);
        check("R8 value restored", f_out, 16'h0040);
    endtask

    task automatic t_reset_mid();
        rst = 1;
        tick();
        rst = 0; in_bypass = 0; out_bypass = 0; #1;
        check("R9 mid-run reset clears output register", f_out, 16'h0000);
        out_bypass = 1; opnd_sel = 2'b11; op_sel = 3'b110; #1;
        check("R9 mid-run reset clears operand registers", f_out, 16'h0000);
        op_sel = 3'b111; opnd_sel = 2'b11; #1;
        check("R9 ones code after reset", f_out, 16'hFFFF);
    endtask

    // One accumulation phase: load A, then load F.
    task automatic acc_step(input logic [2:0] op, input logic [1:0] sel, input logic [W-1:0] av);
        op_sel = op; opnd_sel = sel; a_in = av;
        a_ld_n = 0; f_ld_n = 1;
        tick();
        a_ld_n = 1; f_ld_n = 0;
        tick();
        f_ld_n = 1;
    endtask

    task automatic t_accum(input logic ib, input logic ob);
        logic [W-1:0] exp;
        string tag;
        tag = $sformatf("R10 R6 bypass in=%0d out=%0d", ib, ob);
        in_bypass = ib; out_bypass = ob; b_in = 16'h7777; carry_in = 0;
        acc_step(3'b000, 2'b00, 16'h0003);
        exp = ob ? 16'h0000 : 16'h0000;
        check({tag, " clear"}, f_out, exp);
        acc_step(3'b011, 2'b01, 16'h0007);
        exp = ob ? 16'h0007 : 16'h0007; // live A+0 equals stored value
        check({tag, " preload"}, f_out, exp);
        acc_step(3'b011, 2'b00, 16'h0005);
        exp = ob ? 16'h0011 : 16'h000C; // live shows 5 + 12
        check({tag, " first add"}, f_out, exp);
        acc_step(3'b011, 2'b00, 16'h0010);
        exp = ob ? 16'h002C : 16'h001C;
        check({tag, " second add"}, f_out, exp);
        out_bypass = 0; #1;
        check({tag, " accumulator register"}, f_out, 16'h001C);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2;
        t_reset();
        t_input_regs();
        t_in_bypass();
        t_ops();
        t_opsel();
        t_out_reg();
        t_out_bypass();
        t_oe();
        t_reset_mid();
        for (int ib = 0; ib < 2; ib++)
            for (int ob = 0; ob < 2; ob++)
                t_accum(ib[0], ob[0]);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule